// File: doc/BRIEF.md
# History reset request controller

This block handles the execution side of a privileged request to clear predictor history. A 32-bit selector comes with each request. Each bit of the selector names one history component. Before any component is cleared, the request must pass a chain of checks: the feature must be present, the request must not come from inside a transactional region or from virtual-8086 mode, the privilege level must be zero, and every selected component must be enabled. If all checks pass, one reset line per selected component pulses for a single cycle.

The set of components that can be reset is fixed at build time by the `CAP_MASK` parameter. Software writes an enable register, and the block keeps only the bits that lie inside that capability mask. Each accepted request produces one outcome code on a done strobe, one cycle after acceptance. While that outcome is reported, the request port is not ready. An 8-bit immediate travels with each request, and the block ignores it.

Top module: `hist_reset_ctrl`

## Requirements
- R1: After reset, `en_value` is 0, `done` is 0, `hist_rst` is 0 and `req_ready` is 1.
- R2: An enable write stores `en_wdata & CAP_MASK`, which is visible on `en_value` the next cycle. A request accepted in the same cycle as a write is checked against the old enable value.
- R3: A request is accepted when `req_valid && req_ready`. On the next cycle, `done` is 1 for exactly one cycle and `req_ready` is 0 during that cycle.
- R4: On success (outcome code 0), `hist_rst` equals the selector for that single done cycle, and is 0 on every other cycle.
- R5: A zero selector that passes every fault check reports code 1 (no-op) and pulses nothing.
- R6: If `feat_present` is 0, the outcome is code 2 (undefined opcode), ahead of every other check.
- R7: Otherwise, if `req_txn` is 1, the outcome is code 3 (transaction abort).
- R8: Otherwise, if `req_v86` is 1, the outcome is code 4 (protection fault, virtual-8086).
- R9: Otherwise, if `req_cpl` is nonzero, the outcome is code 5 (protection fault, privilege).
- R10: Otherwise, if `req_sel & ~en_value` is nonzero, the outcome is code 6 (protection fault, enable mask).
- R11: The value of `req_imm` has no effect on outcome or reset pulses.
- R12: No reset line pulses on a cycle whose outcome code is not 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted |
| req_sel | input | WIDTH | Component selector, one bit per history component |
| req_imm | input | 8 | Immediate operand, ignored |
| req_cpl | input | 2 | Current privilege level |
| req_v86 | input | 1 | Virtual-8086 mode flag |
| req_txn | input | 1 | Inside a transactional region |
| feat_present | input | 1 | Feature available |
| en_wr | input | 1 | Enable register write strobe |
| en_wdata | input | WIDTH | Enable register write data |
| en_value | output | WIDTH | Current enable register |
| done | output | 1 | Outcome strobe |
| outcome | output | 3 | Outcome code (0 OK, 1 no-op, 2 undef, 3 abort, 4 v86, 5 priv, 6 mask) |
| hist_rst | output | WIDTH | Per-component history reset pulses |

## Verification
The bench builds the block with `CAP_MASK = 32'h0000_002D`, a sparse mask with four capable bits, so that every enable pattern in the low six bits can be written. It pairs each of those enable values with each of the 64 low selectors, which covers every subset relation between enable and selector, including selectors that touch bits outside the capability mask. It then runs all 32 combinations of feature, transaction, mode and privilege against a few selectors to confirm the fault order. It also drives a write and a request in the same cycle to confirm that the request is checked against the old enable value.

// File: rtl/hist_reset_ctrl.sv
module hist_reset_ctrl #(
  parameter int WIDTH = 32,
  parameter logic [WIDTH-1:0] CAP_MASK = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [WIDTH-1:0] req_sel,
  input  logic [7:0]       req_imm,
  input  logic [1:0]       req_cpl,
  input  logic             req_v86,
  input  logic             req_txn,
  input  logic             feat_present,
  input  logic             en_wr,
  input  logic [WIDTH-1:0] en_wdata,
  output logic [WIDTH-1:0] en_value,
  output logic             done,
  output logic [2:0]       outcome,
  output logic [WIDTH-1:0] hist_rst
);
  localparam logic [2:0] OC_OK = 3'd0, OC_NOP = 3'd1, OC_UD = 3'd2, OC_TXA = 3'd3,
                         OC_V86 = 3'd4, OC_PRIV = 3'd5, OC_MASK = 3'd6;

  logic       accept;
  logic [2:0] verdict;

  assign req_ready = ~done;
  assign accept    = req_valid & req_ready;

  always_comb begin
    if (!feat_present)                 verdict = OC_UD;
    else if (req_txn)                  verdict = OC_TXA;
    else if (req_v86)                  verdict = OC_V86;
    else if (req_cpl != 2'd0)          verdict = OC_PRIV;
    else if ((req_sel & ~en_value) != '0) verdict = OC_MASK;
    else if (req_sel == '0)            verdict = OC_NOP;
    else                               verdict = OC_OK;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_value <= '0;
      done     <= 1'b0;
      outcome  <= OC_OK;
      hist_rst <= '0;
    end else begin
      if (en_wr) en_value <= en_wdata & CAP_MASK;
      done     <= accept;
      outcome  <= accept ? verdict : OC_OK;
      hist_rst <= (accept && verdict == OC_OK) ? req_sel : '0;
    end
  end
endmodule

module hist_reset_ctrl_chk #(
  parameter int WIDTH = 32,
  parameter logic [WIDTH-1:0] CAP_MASK = '1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic             feat_present,
  input logic [WIDTH-1:0] en_value,
  input logic             done,
  input logic [2:0]       outcome,
  input logic [WIDTH-1:0] hist_rst
);
  a_r3_done_follows_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> done);
  a_r3_busy_while_reporting: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !req_ready);
  a_r3_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r4_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
    (hist_rst != '0) |=> (hist_rst == '0));
  a_r4_pulse_enabled: assert property (@(posedge clk) disable iff (!rst_n)
    (hist_rst != '0) |-> ((hist_rst & ~$past(en_value)) == '0));
  a_r12_no_pulse_on_fault: assert property (@(posedge clk) disable iff (!rst_n)
    (hist_rst != '0) |-> (done && outcome == 3'd0));
  a_r6_undef_first: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !feat_present) |=> (outcome == 3'd2));
  a_r2_enable_capable: assert property (@(posedge clk) disable iff (!rst_n)
    (en_value & ~CAP_MASK) == '0);
endmodule

bind hist_reset_ctrl hist_reset_ctrl_chk #(.WIDTH(WIDTH), .CAP_MASK(CAP_MASK)) chk (.*);

// File: tb/hist_reset_ctrl_test.sv
`timescale 1ns/1ps
module hist_reset_ctrl_test;
  localparam int W = 32;
  localparam logic [W-1:0] CAP = 32'h0000_002D;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_v86 = 0, req_txn = 0, feat_present = 1, en_wr = 0;
  logic [W-1:0] req_sel = '0, en_wdata = '0;
  logic [7:0] req_imm = '0;
  logic [1:0] req_cpl = '0;
  logic req_ready, done;
  logic [W-1:0] en_value, hist_rst;
  logic [2:0] outcome;
  logic [W-1:0] model_en = '0;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  hist_reset_ctrl #(.WIDTH(W), .CAP_MASK(CAP)) uut (.*);

  task automatic chk(input bit ok, input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [2:0] model(input logic [W-1:0] s, input logic [1:0] c,
                                       input bit v, input bit t, input bit f, input logic [W-1:0] e);
    if (!f) return 3'd2;
    if (t) return 3'd3;
    if (v) return 3'd4;
    if (c != 0) return 3'd5;
    if ((s & ~e) != 0) return 3'd6;
    if (s == 0) return 3'd1;
    return 3'd0;
  endfunction

  task automatic wr_en(input logic [W-1:0] d);
    @(negedge clk); en_wr = 1; en_wdata = d;
    @(negedge clk); en_wr = 0;
    model_en = d & CAP;
    chk(en_value == model_en, "R2 enable write masked", en_value, model_en);
  endtask

  task automatic do_req(input logic [W-1:0] s, input logic [7:0] im, input logic [1:0] c,
                        input bit v, input bit t, input bit f, input string tag);
    logic [2:0] e;
    logic [W-1:0] er;
    e = model(s, c, v, t, f, model_en);
    er = (e == 3'd0) ? s : '0;
    @(negedge clk);
    req_valid = 1; req_sel = s; req_imm = im; req_cpl = c; req_v86 = v; req_txn = t; feat_present = f;
    @(negedge clk);
    req_valid = 0;
    chk(done && !req_ready && outcome == e && hist_rst == er, tag,
        {outcome, hist_rst[W-4:0]}, {e, er[W-4:0]});
    @(negedge clk);
    chk(!done && req_ready && hist_rst == '0, "R4 R3 single cycle pulse and ready back",
        {done, req_ready, hist_rst[W-3:0]}, {2'b01, {(W-2){1'b0}}});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(en_value == '0 && !done && hist_rst == '0 && req_ready, "R1 reset state",
        {en_value[W-4:0], done, req_ready, |hist_rst}, {{(W-3){1'b0}}, 3'b010});
    rst_n = 1;

    for (int d = 0; d < 64; d++) wr_en(W'(d) | 32'hA5A0_0000);

    for (int e = 0; e < 64; e++) begin
      wr_en(W'(e));
      for (int s = 0; s < 64; s++)
        do_req(W'(s), 8'(s ^ e), 2'd0, 0, 0, 1, "R4 R5 R10 R11 R12 sweep outcome");
    end

    wr_en(CAP);
    for (int k = 0; k < 32; k++) begin
      logic [W-1:0] sels [4];
      sels = '{32'h0, 32'h1, 32'h40, CAP};
      for (int j = 0; j < 4; j++)
        do_req(sels[j], 8'(k * 7), 2'(k), k[2], k[3], k[4], "R6 R7 R8 R9 R10 fault priority");
    end

    wr_en('0);
    @(negedge clk);
    en_wr = 1; en_wdata = CAP;
    req_valid = 1; req_sel = 32'h1; req_cpl = 0; req_v86 = 0; req_txn = 0; feat_present = 1;
    @(negedge clk);
    en_wr = 0; req_valid = 0;
    chk(done && outcome == 3'd6 && hist_rst == '0, "R2 same-cycle write uses old enable",
        {29'd0, outcome}, {29'd0, 3'd6});
    model_en = CAP;
    do_req(32'h1, 8'h00, 2'd0, 0, 0, 1, "R2 write visible next request");

    do_req(32'h5, 8'h00, 2'd0, 0, 0, 1, "R11 imm zero");
    do_req(32'h5, 8'hFF, 2'd0, 0, 0, 1, "R11 imm all ones");
    do_req(32'h0, 8'h3C, 2'd0, 0, 0, 1, "R5 zero selector no-op");
    do_req(32'h1, 8'h00, 2'd3, 0, 0, 1, "R9 privilege 3");
    do_req(32'h8000_0000, 8'h00, 2'd0, 0, 0, 1, "R10 bit outside capability");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule